// File: doc/BRIEF.md
# FIFO Almost-Flag Offset Programmer

This block sits beside the storage of a deep synchronous FIFO. It holds the two threshold offsets that the flag logic compares against: one for the almost-empty flag and one for the almost-full flag. A master reset loads both offsets with a default value. The same reset also fixes, until the next master reset, whether new offsets arrive as parallel words or as a serial bit stream. The load strobe level sampled during master reset decides both choices.

Outside master reset, every command is sampled on the write clock. It is built from an active-low load strobe and active-low write, read and serial enables. With the strobe high, the enables are passed on to the FIFO core as memory write and memory read strobes. With the strobe low, the enables address the offset registers instead. One shared pointer steps through the two registers in turn, empty offset first, for parallel writes and for read-back. Serial loading fills both registers through a single 26-bit chain.

Top module: `fifo_offset_prog`

## Requirements
- R1: During master reset (`mrst` high at a clock edge), both offsets are loaded with 0x07F if `load_n` is low, or with 0x3FF if `load_n` is high.
- R2: `ser_mode` is set to 1 (serial method) when `load_n` is low at master reset, and to 0 (parallel method) when `load_n` is high. It keeps that value until the next master reset, whatever the enables do.
- R3: In parallel mode, a clock edge with `load_n`=0, `wr_n`=0, `rd_n`=1 and `ser_n`=1 stores `din[12:0]`. The first such write goes to the empty offset, the next to the full offset, and the order then repeats.
- R4: A clock edge with `load_n`=0, `rd_n`=0, `wr_n`=1 and `ser_n`=1 puts the addressed offset on `dout` from the following cycle onward, with `dout[17:13]` set to zero. Read-back is allowed in both modes.
- R5: In serial mode, each edge with `load_n`=0, `ser_n`=0, `wr_n`=1 and `rd_n`=1 shifts in `ser_in`. After 26 shifts, the first bit sent is bit 0 of the empty offset and the last bit sent is bit 12 of the full offset.
- R6: While `load_n` is high, `mem_wr` follows the inverse of `wr_n` and `mem_rd` follows the inverse of `rd_n`, within the same cycle. While `load_n` is low, neither strobe is asserted.
- R7: With `load_n` low, any other enable combination changes neither offset, the pointer nor `dout`. This covers all enables high, and more than one enable low.
- R8: One pointer serves both parallel writes and reads. It starts at the empty offset after master reset, moves on after each accepted access, and returns to the empty offset after the full offset has been accessed.
- R9: A parallel write in serial mode and a shift in parallel mode are ignored. They leave both offsets and the pointer unchanged.
- R10: While `mrst` is high, `mem_wr` and `mem_rd` stay low and no register command takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock; all commands are sampled on its rising edge |
| mrst | input | 1 | Master reset, active high, synchronous |
| load_n | input | 1 | Load strobe, active low: register access when low, memory access when high |
| wr_n | input | 1 | Write enable, active low |
| rd_n | input | 1 | Read enable, active low |
| ser_n | input | 1 | Serial shift enable, active low |
| ser_in | input | 1 | Serial data bit |
| din | input | 18 | Parallel data bus; the low 13 bits carry an offset |
| dout | output | 18 | Offset read-back, zero-filled above bit 12 |
| mem_wr | output | 1 | Memory write strobe to the FIFO core |
| mem_rd | output | 1 | Memory read strobe to the FIFO core |
| empty_ofs | output | 13 | Almost-empty offset to the flag logic |
| full_ofs | output | 13 | Almost-full offset to the flag logic |
| ser_mode | output | 1 | Latched programming method, 1 = serial |

## Verification
The assertions assume that `mrst` is high on the first clock edge. This defines the offsets, the method and the pointer before any property leaves its disable condition. They also assume that every input is stable around the rising edge. The bench meets both assumptions: it holds `mrst` from time zero through the first edge, and it changes every input only on the falling edge. The register checks then sample one time unit after the rising edge, and the memory strobes are checked within the same low phase in which they were driven.

// File: rtl/fop_pkg.sv
package fop_pkg;

  // decoded command for one write-clock cycle
  typedef struct packed {
    logic reg_wr;
    logic reg_rd;
    logic shift;
    logic mem_wr;
    logic mem_rd;
  } fop_cmd_t;

  // reset default chosen by load strobe level
  function automatic logic [31:0] def_pick(input logic load_n,
                                           input logic [31:0] lo,
                                           input logic [31:0] hi);
    return load_n ? hi : lo;
  endfunction

endpackage

// File: rtl/fop_decode.sv
module fop_decode
  import fop_pkg::*;
(
  input  logic     clk,
  input  logic     mrst,
  input  logic     load_n,
  input  logic     wr_n,
  input  logic     rd_n,
  input  logic     ser_n,
  output fop_cmd_t cmd
);

  logic reg_sel;
  logic mem_sel;

  assign reg_sel = !mrst && !load_n;
  assign mem_sel = !mrst && load_n;

  always_comb begin
    cmd        = '0;
    cmd.reg_wr = reg_sel && !wr_n &&  rd_n &&  ser_n;
    cmd.reg_rd = reg_sel &&  wr_n && !rd_n &&  ser_n;
    cmd.shift  = reg_sel &&  wr_n &&  rd_n && !ser_n;
    cmd.mem_wr = mem_sel && !wr_n;
    cmd.mem_rd = mem_sel && !rd_n;
  end

  // R6: register traffic and memory traffic never share a cycle
  p_reg_vs_mem_r6: assert property (@(posedge clk) disable iff (mrst)
    (cmd.reg_wr || cmd.reg_rd || cmd.shift) |-> !(cmd.mem_wr || cmd.mem_rd));

  // R7: at most one register command per cycle
  p_one_reg_cmd_r7: assert property (@(posedge clk) disable iff (mrst)
    $onehot0({cmd.reg_wr, cmd.reg_rd, cmd.shift}));

endmodule

// File: rtl/fop_ptr.sv
module fop_ptr (
  input  logic clk,
  input  logic mrst,
  input  logic adv,
  output logic sel
);

  always_ff @(posedge clk) begin
    if (mrst)      sel <= 1'b0;
    else if (adv)  sel <= !sel;
  end

  // R8: pointer starts at empty offset after reset
  p_ptr_home_r8: assert property (@(posedge clk) disable iff (mrst)
    $past(mrst) |-> !sel);

  // R8: after the full offset is accessed, back to the empty offset
  p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (mrst)
    (adv && sel) |=> !sel);

  // R7: pointer holds without an accepted access
  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (mrst)
    !adv |=> $stable(sel));

endmodule

// File: rtl/fop_regs.sv
module fop_regs
  import fop_pkg::*;
#(
  parameter int OFS_W  = 13,
  parameter int DEF_LO = 'h07F,
  parameter int DEF_HI = 'h3FF
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             load_n,
  input  logic             acc_wr,
  input  logic             acc_shift,
  input  logic             rd_evt,
  input  logic             sel,
  input  logic [OFS_W-1:0] din_ofs,
  input  logic             ser_in,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs,
  output logic [OFS_W-1:0] rd_q,
  output logic             ser_mode
);

  localparam int CHAIN_W = 2 * OFS_W;

  logic [OFS_W-1:0]   dflt;
  logic [CHAIN_W-1:0] chain_nxt;

  // new bit enters at the full-offset MSB, moves toward empty-offset LSB
  function automatic logic [CHAIN_W-1:0] shift_chain(input logic [CHAIN_W-1:0] c,
                                                     input logic b);
    return {b, c[CHAIN_W-1:1]};
  endfunction

  assign dflt      = OFS_W'(def_pick(load_n, DEF_LO, DEF_HI));
  assign chain_nxt = shift_chain({full_ofs, empty_ofs}, ser_in);

  always_ff @(posedge clk) begin
    if (mrst) begin
      empty_ofs <= dflt;
      full_ofs  <= dflt;
      ser_mode  <= !load_n;
      rd_q      <= '0;
    end else begin
      if (acc_shift) begin
        {full_ofs, empty_ofs} <= chain_nxt;
      end else if (acc_wr) begin
        if (sel) full_ofs  <= din_ofs;
        else     empty_ofs <= din_ofs;
      end
      if (rd_evt) rd_q <= sel ? full_ofs : empty_ofs;
    end
  end

  // R1: defaults follow the strobe level of the last reset cycle
  p_defaults_r1: assert property (@(posedge clk) disable iff (mrst)
    $past(mrst) |-> (empty_ofs == full_ofs) &&
                    (empty_ofs == ($past(load_n) ? OFS_W'(DEF_HI) : OFS_W'(DEF_LO))));

  // R2: method never changes outside master reset
  p_mode_locked_r2: assert property (@(posedge clk) disable iff (mrst)
    !$past(mrst) |-> $stable(ser_mode));

  // R9: in serial mode only shifts may alter the offsets
  p_serial_only_r9: assert property (@(posedge clk) disable iff (mrst)
    (ser_mode && !acc_shift) |=> ($stable(empty_ofs) && $stable(full_ofs)));

  // R9: in parallel mode only parallel writes may alter the offsets
  p_parallel_only_r9: assert property (@(posedge clk) disable iff (mrst)
    (!ser_mode && !acc_wr) |=> ($stable(empty_ofs) && $stable(full_ofs)));

  // R5: chain links full LSB to empty MSB and takes ser_in at the top
  p_chain_link_r5: assert property (@(posedge clk) disable iff (mrst)
    acc_shift |=> (empty_ofs[OFS_W-1] == $past(full_ofs[0])) &&
                  (full_ofs[OFS_W-1] == $past(ser_in)));

  // R4: read of the empty slot returns the empty offset
  p_read_empty_r4: assert property (@(posedge clk) disable iff (mrst)
    (rd_evt && !sel) |=> rd_q == $past(empty_ofs));

  // R4: read of the full slot returns the full offset
  p_read_full_r4: assert property (@(posedge clk) disable iff (mrst)
    (rd_evt && sel) |=> rd_q == $past(full_ofs));

endmodule

// File: rtl/fifo_offset_prog.sv
module fifo_offset_prog
  import fop_pkg::*;
#(
  parameter int BUS_W  = 18,
  parameter int OFS_W  = 13,
  parameter int DEF_LO = 'h07F,
  parameter int DEF_HI = 'h3FF
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             load_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             ser_n,
  input  logic             ser_in,
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] dout,
  output logic             mem_wr,
  output logic             mem_rd,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs,
  output logic             ser_mode
);

  localparam int PAD_W = BUS_W - OFS_W;

  function automatic logic [BUS_W-1:0] zfill(input logic [OFS_W-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  fop_cmd_t         cmd;
  logic             acc_wr;
  logic             acc_shift;
  logic             ptr_adv;
  logic             sel;
  logic [OFS_W-1:0] rd_q;

  fop_decode u_dec (
    .clk    (clk),
    .mrst   (mrst),
    .load_n (load_n),
    .wr_n   (wr_n),
    .rd_n   (rd_n),
    .ser_n  (ser_n),
    .cmd    (cmd)
  );

  // mode gating of register commands
  assign acc_wr    = cmd.reg_wr && !ser_mode;
  assign acc_shift = cmd.shift  &&  ser_mode;
  assign ptr_adv   = acc_wr || cmd.reg_rd;

  fop_ptr u_ptr (
    .clk  (clk),
    .mrst (mrst),
    .adv  (ptr_adv),
    .sel  (sel)
  );

  fop_regs #(
    .OFS_W  (OFS_W),
    .DEF_LO (DEF_LO),
    .DEF_HI (DEF_HI)
  ) u_regs (
    .clk       (clk),
    .mrst      (mrst),
    .load_n    (load_n),
    .acc_wr    (acc_wr),
    .acc_shift (acc_shift),
    .rd_evt    (cmd.reg_rd),
    .sel       (sel),
    .din_ofs   (din[OFS_W-1:0]),
    .ser_in    (ser_in),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .rd_q      (rd_q),
    .ser_mode  (ser_mode)
  );

  assign dout   = zfill(rd_q);
  assign mem_wr = cmd.mem_wr;
  assign mem_rd = cmd.mem_rd;

  // R10: no memory strobe while master reset is held
  always_comb begin
    if (mrst) begin
      p_mem_quiet_r10: assert (!mem_wr && !mem_rd);
    end
  end

  // R6: memory strobes only when the load strobe is high
  p_mem_needs_load_r6: assert property (@(posedge clk) disable iff (mrst)
    (mem_wr || mem_rd) |-> load_n);

  // R4: upper read-back bits stay zero
  p_zero_fill_r4: assert property (@(posedge clk) disable iff (mrst)
    dout[BUS_W-1:OFS_W] == '0);

endmodule

// File: tb/sim_fifo_offset_prog.sv
module sim_fifo_offset_prog;

  logic        clk = 1'b0;
  logic        mrst = 1'b1;
  logic        load_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        rd_n = 1'b1;
  logic        ser_n = 1'b1;
  logic        ser_in = 1'b0;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic        mem_wr;
  logic        mem_rd;
  logic [12:0] empty_ofs;
  logic [12:0] full_ofs;
  logic        ser_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fifo_offset_prog u0 (
    .clk(clk), .mrst(mrst), .load_n(load_n), .wr_n(wr_n), .rd_n(rd_n),
    .ser_n(ser_n), .ser_in(ser_in), .din(din), .dout(dout),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .empty_ofs(empty_ofs),
    .full_ofs(full_ofs), .ser_mode(ser_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on falling edge, settle
  task automatic drive(input logic l, w, r, s, si, input logic [17:0] d);
    @(negedge clk);
    load_n = l; wr_n = w; rd_n = r; ser_n = s; ser_in = si; din = d;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic l);
    @(negedge clk);
    mrst = 1'b1; load_n = l; wr_n = 1'b0; rd_n = 1'b0; ser_n = 1'b1;
    #1;
    chk("R10 mem_wr in reset", mem_wr, 0);
    chk("R10 mem_rd in reset", mem_rd, 0);
    tick();
    @(negedge clk);
    mrst = 1'b0; wr_n = 1'b1; rd_n = 1'b1;
  endtask

  // {ld,wr,rd,sn, din[17:0], mw,mr, e[12:0], f[12:0], dout[17:0]}
  localparam int NV = 12;
  localparam logic [67:0] TBL [NV] = '{
    {4'b1011, 18'h00000, 2'b10, 13'h03FF, 13'h03FF, 18'h00000}, // mem write
    {4'b1101, 18'h00000, 2'b01, 13'h03FF, 13'h03FF, 18'h00000}, // mem read
    {4'b0011, 18'h30123, 2'b00, 13'h0123, 13'h03FF, 18'h00000}, // wr empty
    {4'b0011, 18'h01ABC, 2'b00, 13'h0123, 13'h1ABC, 18'h00000}, // wr full
    {4'b0101, 18'h00000, 2'b00, 13'h0123, 13'h1ABC, 18'h00123}, // rd empty
    {4'b0101, 18'h00000, 2'b00, 13'h0123, 13'h1ABC, 18'h01ABC}, // rd full
    {4'b0111, 18'h00000, 2'b00, 13'h0123, 13'h1ABC, 18'h01ABC}, // nop
    {4'b0001, 18'h00777, 2'b00, 13'h0123, 13'h1ABC, 18'h01ABC}, // wr+rd nop
    {4'b0110, 18'h00000, 2'b00, 13'h0123, 13'h1ABC, 18'h01ABC}, // shift ignored
    {4'b0011, 18'h00055, 2'b00, 13'h0055, 13'h1ABC, 18'h01ABC}, // wr empty
    {4'b0101, 18'h00000, 2'b00, 13'h0055, 13'h1ABC, 18'h01ABC}, // rd full (shared ptr)
    {4'b0101, 18'h00000, 2'b00, 13'h0055, 13'h1ABC, 18'h00055}  // rd empty (wrap)
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [25:0] chain;
    // parallel method, high defaults
    tick();
    do_reset(1'b1);
    #1;
    chk("R1 empty default high", empty_ofs, 13'h3FF);
    chk("R1 full default high", full_ofs, 13'h3FF);
    chk("R2 parallel mode", ser_mode, 0);
    chk("R4 dout after reset", dout, 0);

    for (int i = 0; i < NV; i++) begin
      logic [67:0] v;
      v = TBL[i];
      drive(v[67], v[66], v[65], v[64], 1'b1, v[63:46]);
      chk($sformatf("R6 mem_wr vec %0d", i), mem_wr, v[45]);
      chk($sformatf("R6 mem_rd vec %0d", i), mem_rd, v[44]);
      tick();
      chk($sformatf("R3 R7 R9 empty vec %0d", i), empty_ofs, v[43:31]);
      chk($sformatf("R3 R7 R9 full vec %0d", i), full_ofs, v[30:18]);
      chk($sformatf("R4 R8 dout vec %0d", i), dout, v[17:0]);
    end
    chk("R2 mode held", ser_mode, 0);

    // serial method, low defaults
    do_reset(1'b0);
    #1;
    chk("R1 empty default low", empty_ofs, 13'h07F);
    chk("R1 full default low", full_ofs, 13'h07F);
    chk("R2 serial mode", ser_mode, 1);

    chain = {13'h15C3, 13'h0A5A};
    for (int i = 0; i < 26; i++) begin
      drive(1'b0, 1'b1, 1'b1, 1'b0, chain[i], 18'h0);
      tick();
    end
    chk("R5 empty after chain", empty_ofs, 13'h0A5A);
    chk("R5 full after chain", full_ofs, 13'h15C3);

    // parallel write ignored in serial mode, pointer stays home
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 18'h3FFFF);
    tick();
    chk("R9 empty kept", empty_ofs, 13'h0A5A);
    chk("R9 full kept", full_ofs, 13'h15C3);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 18'h0);
    tick();
    chk("R9 R4 read empty in serial mode", dout, 18'h00A5A);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 18'h0);
    tick();
    chk("R4 read full in serial mode", dout, 18'h015C3);
    chk("R2 serial mode held", ser_mode, 1);

    // pointer returns home at master reset
    do_reset(1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 18'h00011);
    tick();
    chk("R3 first write to empty", empty_ofs, 13'h0011);
    do_reset(1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 18'h00022);
    tick();
    chk("R8 pointer home after reset", empty_ofs, 13'h0022);
    chk("R8 full untouched", full_ofs, 13'h03FF);

    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 18'h0);
    chk("R6 no mem strobes idle", {30'b0, mem_wr, mem_rd}, 0);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 18'h0);
    chk("R6 both mem strobes", {30'b0, mem_wr, mem_rd}, 3);
    tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule